// File: doc/BRIEF.md
# Configurable Memory Map Decoder

This block sits beside the address generator of a 16-bit processor core. For every access it receives a space select (program, data or I/O) and a 16-bit word address. It answers in the same cycle with a one-hot region select and the word offset inside that region. It also raises a bus-request output when the access lands in the shared global window at the top of data space. The decode itself is purely combinational. The mode state that shapes the map is held in registers inside the block.

That state has several parts. A processor/controller mode bit is captured from a pin while reset is held. A block-configuration bit moves the small block B0 between data and program space. Two enable bits map a 4K on-chip RAM into program space, data space or both. A global-window register sets the size of the global window and can switch it off. Software rewrites the state through two write strobes. Small blocks B0 and B1 each answer at two adjacent 256-word ranges, and both ranges reach the same words.

Top module: `memmap_decoder`

## Requirements
- R1: When `acc_valid` is high, exactly one bit of `region_sel` is set. The bits are: bit0 register space, bit1 flash, bit2 4K RAM, bit3 B0, bit4 B1, bit5 external. When `acc_valid` is low, `region_sel` is zero and `bus_req` is low. Space code 2 (I/O) always selects external. `ext_acc` mirrors bit5.
- R2: Data addresses 0000h–005Fh select register space, and `local_addr` equals the address.
- R3: When the global window is enabled (`gm_wdata[3]`) with size n (`gm_wdata[2:0]`), data addresses at or above 10000h − 256·2^n select external and raise `bus_req`. The window never applies to program or I/O space, and it does nothing while disabled.
- R4: Reset is synchronous and active low. While `rst_n` is low, the mode bit is loaded from `mode_pin`, both RAM enables are set, the configuration bit is cleared and the global window is disabled.
- R5: When the data enable (`ctl_wdata[3]`) is 1, data 0800h–17FFh selects the 4K RAM with `local_addr` = address − 0800h. When the program enable (`ctl_wdata[2]`) is 1, program 8000h–8FFFh selects it with `local_addr` = address − 8000h.
- R6: Mode bit (`ctl_wdata[0]`) = 1 makes program 0000h–7FFFh external. Mode bit = 0 makes that range select flash, with `local_addr` equal to the address.
- R7: With the configuration bit (`ctl_wdata[1]`) at 0, B0 answers at data 0100h–02FFh and `local_addr` is the low 8 address bits, so mirrored addresses give the same offset. Program FE00h–FFFFh is then external.
- R8: With the configuration bit at 1, B0 answers at program FE00h–FFFFh with `local_addr` equal to the low 8 bits. Data 0100h–02FFh is then external.
- R9: B1 answers at data 0300h–04FFh in every configuration, with `local_addr` equal to the low 8 bits.
- R10: Every other address selects external, with `local_addr` equal to the address and `bus_req` low.
- R11: A write on `ctl_we` or `gm_we` takes effect from the next clock edge. An access in the write cycle decodes with the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pin | input | 1 | Mode level captured during reset |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_wdata | input | 4 | {data RAM en, program RAM en, block cfg, mode} |
| gm_we | input | 1 | Write strobe for the global window register |
| gm_wdata | input | 4 | {enable, size n[2:0]} |
| acc_valid | input | 1 | Access present this cycle |
| acc_space | input | 2 | 0 program, 1 data, 2 I/O |
| acc_addr | input | 16 | Word address |
| region_sel | output | 6 | One-hot region select |
| local_addr | output | 16 | Offset inside the selected region |
| ext_acc | output | 1 | Access goes off chip |
| bus_req | output | 1 | Access lies in the global window |

## Verification
The decode and a state update can fall in the same cycle. An access on the same address can arrive while `ctl_we` or `gm_we` is high. The bench provokes this by clearing the mode bit and enlarging the global window while program 0000h and data 8000h are presented. It requires the old decode before the edge and the new one after it. Mirror pairs and both edges of each range are probed under every configuration.

// File: rtl/memmap_pkg.sv
// Shared encodings for the memory map decoder.
// Assumes a 16-bit word address and three address spaces.
package memmap_pkg;
    typedef enum logic [1:0] {
        SP_PROG = 2'd0,
        SP_DATA = 2'd1,
        SP_IO   = 2'd2
    } space_t;

    localparam int NREG    = 6;
    localparam int RG_MMR  = 0;
    localparam int RG_FLSH = 1;
    localparam int RG_RAM  = 2;
    localparam int RG_B0   = 3;
    localparam int RG_B1   = 4;
    localparam int RG_EXT  = 5;

    typedef struct packed {
        logic       mode_mp;
        logic       blk_cfg;
        logic       ram_pen;
        logic       ram_den;
        logic       gm_en;
        logic [2:0] gm_size;
    } map_state_t;
endpackage

// File: rtl/mode_regs.sv
// Holds the map-shaping state.
// The mode bit is captured from a pin while reset is low.
// Assumes a synchronous active-low reset. Writes land at the clock edge.
module mode_regs
    import memmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_pin,
    input  logic       ctl_we,
    input  logic [3:0] ctl_wdata,
    input  logic       gm_we,
    input  logic [3:0] gm_wdata,
    output map_state_t st
);
    // Control bits: reset defaults, or the software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.mode_mp <= mode_pin;
            st.blk_cfg <= 1'b0;
            st.ram_pen <= 1'b1;
            st.ram_den <= 1'b1;
        end else if (ctl_we) begin
            st.mode_mp <= ctl_wdata[0];
            st.blk_cfg <= ctl_wdata[1];
            st.ram_pen <= ctl_wdata[2];
            st.ram_den <= ctl_wdata[3];
        end
    end

    // Global window register: disabled at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.gm_en   <= 1'b0;
            st.gm_size <= 3'd0;
        end else if (gm_we) begin
            st.gm_en   <= gm_wdata[3];
            st.gm_size <= gm_wdata[2:0];
        end
    end
endmodule

// File: rtl/global_window.sv
// Flags addresses inside the global window at the top of the space.
// The window is 2^(MIN_LOG2+size) words, ending at the highest address.
// Assumes MIN_LOG2 + 7 <= ADDR_W.
module global_window #(
    parameter int ADDR_W   = 16,
    parameter int MIN_LOG2 = 8
) (
    input  logic              en,
    input  logic [2:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W-1:0] top_mask;

    // The address is in the window when all of its upper bits are set.
    always_comb begin
        top_mask = {ADDR_W{1'b1}} << (MIN_LOG2 + int'(size));
        hit      = en && (&(addr | ~top_mask));
    end
endmodule

// File: rtl/space_decoder.sv
// Combinational region decode for a single access.
// Priority: register space, then global window, then on-chip blocks,
// then external.
// Assumes the ranges in the parameters do not run past the top address.
module space_decoder
    import memmap_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          MMR_WORDS = 96,
    parameter int          BLK_LOG2  = 8,
    parameter int          RAM_WORDS = 4096,
    parameter int          FLASH_WDS = 32768,
    parameter logic [15:0] B0_DBASE  = 16'h0100,
    parameter logic [15:0] B1_DBASE  = 16'h0300,
    parameter logic [15:0] B0_PBASE  = 16'hFE00,
    parameter logic [15:0] RAM_DBASE = 16'h0800,
    parameter logic [15:0] RAM_PBASE = 16'h8000
) (
    input  logic              acc_valid,
    input  logic [1:0]        acc_space,
    input  logic [ADDR_W-1:0] acc_addr,
    input  map_state_t        st,
    input  logic              gbl_hit,
    output logic [NREG-1:0]   region_sel,
    output logic [ADDR_W-1:0] local_addr,
    output logic              bus_req
);
    localparam int MIRROR_WDS = 2 << BLK_LOG2;

    typedef struct packed {
        logic              in;
        logic [ADDR_W-1:0] off;
    } rng_t;

    // Window test: the offset from the base is valid only at or above the base.
    function automatic rng_t in_rng(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base,
                                    input int                words);
        rng_t r;
        r.off = a - base;
        r.in  = (a >= base) && (int'(r.off) < words);
        return r;
    endfunction

    rng_t r_b0d, r_b1d, r_b0p, r_ramd, r_ramp, r_flash;
    logic is_prog, is_data;

    // Range matches for every candidate region.
    always_comb begin
        is_prog = (acc_space == SP_PROG);
        is_data = (acc_space == SP_DATA);
        r_b0d   = in_rng(acc_addr, B0_DBASE, MIRROR_WDS);
        r_b1d   = in_rng(acc_addr, B1_DBASE, MIRROR_WDS);
        r_b0p   = in_rng(acc_addr, B0_PBASE, MIRROR_WDS);
        r_ramd  = in_rng(acc_addr, RAM_DBASE, RAM_WORDS);
        r_ramp  = in_rng(acc_addr, RAM_PBASE, RAM_WORDS);
        r_flash = in_rng(acc_addr, '0, FLASH_WDS);
    end

    // Priority selection of one region and its local offset.
    always_comb begin
        region_sel = '0;
        local_addr = acc_addr;
        bus_req    = 1'b0;
        if (acc_valid) begin
            if (is_data && int'(acc_addr) < MMR_WORDS) begin
                region_sel[RG_MMR] = 1'b1;
            end else if (is_data && gbl_hit) begin
                region_sel[RG_EXT] = 1'b1;
                bus_req            = 1'b1;
            end else if (is_data && !st.blk_cfg && r_b0d.in) begin
                region_sel[RG_B0] = 1'b1;
                local_addr        = ADDR_W'(r_b0d.off[BLK_LOG2-1:0]);
            end else if (is_data && r_b1d.in) begin
                region_sel[RG_B1] = 1'b1;
                local_addr        = ADDR_W'(r_b1d.off[BLK_LOG2-1:0]);
            end else if (is_data && st.ram_den && r_ramd.in) begin
                region_sel[RG_RAM] = 1'b1;
                local_addr         = r_ramd.off;
            end else if (is_prog && !st.mode_mp && r_flash.in) begin
                region_sel[RG_FLSH] = 1'b1;
                local_addr          = r_flash.off;
            end else if (is_prog && st.ram_pen && r_ramp.in) begin
                region_sel[RG_RAM] = 1'b1;
                local_addr         = r_ramp.off;
            end else if (is_prog && st.blk_cfg && r_b0p.in) begin
                region_sel[RG_B0] = 1'b1;
                local_addr        = ADDR_W'(r_b0p.off[BLK_LOG2-1:0]);
            end else begin
                region_sel[RG_EXT] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/memmap_decoder.sv
// Top of the memory map decoder: mode state, global window test and
// region decode. Outputs follow the access inputs in the same cycle.
// State writes take effect at the next clock edge.
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int MIN_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pin,
    input  logic              ctl_we,
    input  logic [3:0]        ctl_wdata,
    input  logic              gm_we,
    input  logic [3:0]        gm_wdata,
    input  logic              acc_valid,
    input  logic [1:0]        acc_space,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [NREG-1:0]   region_sel,
    output logic [ADDR_W-1:0] local_addr,
    output logic              ext_acc,
    output logic              bus_req
);
    map_state_t st;
    logic       gbl_hit;

    mode_regs u_regs (
        .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .gm_we(gm_we), .gm_wdata(gm_wdata), .st(st)
    );

    global_window #(.ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2)) u_gw (
        .en(st.gm_en), .size(st.gm_size), .addr(acc_addr), .hit(gbl_hit)
    );

    space_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .acc_valid(acc_valid), .acc_space(acc_space), .acc_addr(acc_addr),
        .st(st), .gbl_hit(gbl_hit), .region_sel(region_sel),
        .local_addr(local_addr), .bus_req(bus_req)
    );

    // External flag taken from the one-hot select.
    assign ext_acc = region_sel[RG_EXT];
endmodule

// File: rtl/memmap_decoder_chk.sv
// Property checker for memmap_decoder, attached by the bind below.
module memmap_decoder_chk
    import memmap_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic [1:0]      acc_space,
    input logic [15:0]     acc_addr,
    input logic [NREG-1:0] region_sel,
    input logic            ext_acc,
    input logic            bus_req
);
    AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $countones(region_sel) == 1); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (region_sel == '0) && !bus_req); // R1
    AST_IO_EXTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_space == SP_IO) |-> ext_acc); // R1
    AST_MMR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_space == SP_DATA && acc_addr < 16'h0060)
        |-> region_sel[RG_MMR] && !bus_req); // R2
    AST_BUSREQ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> acc_valid && acc_space == SP_DATA && ext_acc); // R3
    AST_B1_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_space == SP_DATA && acc_addr >= 16'h0300
         && acc_addr <= 16'h04FF) |-> region_sel[RG_B1]); // R9
endmodule

bind memmap_decoder memmap_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_space(acc_space),
    .acc_addr(acc_addr), .region_sel(region_sel), .ext_acc(ext_acc),
    .bus_req(bus_req)
);

// File: tb/sim_memmap_decoder.sv
// Directed bench for memmap_decoder.
// Inputs change on the falling edge, and outputs are sampled 2 ns later.
module sim_memmap_decoder;
    localparam logic [5:0] S_MMR = 6'b000001, S_FL = 6'b000010,
                           S_RAM = 6'b000100, S_B0 = 6'b001000,
                           S_B1  = 6'b010000, S_EX = 6'b100000;

    logic        clk = 1'b0, rst_n = 1'b0, mode_pin = 1'b1;
    logic        ctl_we = 1'b0, gm_we = 1'b0, acc_valid = 1'b0;
    logic [3:0]  ctl_wdata = '0, gm_wdata = '0;
    logic [1:0]  acc_space = '0;
    logic [15:0] acc_addr = '0, local_addr;
    logic [5:0]  region_sel;
    logic        ext_acc, bus_req;
    int          checks = 0, failures = 0;

    always #10 clk = ~clk;

    memmap_decoder u0 (
        .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .gm_we(gm_we), .gm_wdata(gm_wdata),
        .acc_valid(acc_valid), .acc_space(acc_space), .acc_addr(acc_addr),
        .region_sel(region_sel), .local_addr(local_addr), .ext_acc(ext_acc),
        .bus_req(bus_req)
    );

    task automatic compare(input string tag, input logic [5:0] es,
                           input logic [15:0] el, input logic eb);
        checks++;
        if (region_sel !== es || local_addr !== el || bus_req !== eb
            || ext_acc !== es[5]) begin
            failures++;
            $display("FAIL %s: sel=%b loc=%h bus=%b ext=%b expected sel=%b loc=%h bus=%b",
                     tag, region_sel, local_addr, bus_req, ext_acc, es, el, eb);
        end
    endtask

    // Present an access at the falling edge and check it.
    task automatic probe(input string tag, input logic [1:0] sp,
                         input logic [15:0] a, input logic [5:0] es,
                         input logic [15:0] el, input logic eb);
        @(negedge clk);
        acc_valid = 1'b1; acc_space = sp; acc_addr = a;
        #2 compare(tag, es, el, eb);
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n = 1'b0; mode_pin = pin; acc_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_ctl(input logic [3:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic write_gm(input logic [3:0] v);
        @(negedge clk); gm_we = 1'b1; gm_wdata = v;
        @(negedge clk); gm_we = 1'b0;
    endtask

    task automatic t_reset_defaults;
        do_reset(1'b1);
        #2 compare("R1 idle", 6'b0, 16'h0000, 1'b0);
        probe("R4 pin high prog 0000", 2'd0, 16'h0000, S_EX, 16'h0000, 1'b0);
        probe("R6 mode1 prog 7FFF", 2'd0, 16'h7FFF, S_EX, 16'h7FFF, 1'b0);
        probe("R4 R5 data 0800", 2'd1, 16'h0800, S_RAM, 16'h0000, 1'b0);
        probe("R5 data 17FF", 2'd1, 16'h17FF, S_RAM, 16'h0FFF, 1'b0);
        probe("R10 data 1800", 2'd1, 16'h1800, S_EX, 16'h1800, 1'b0);
        probe("R5 prog 8000", 2'd0, 16'h8000, S_RAM, 16'h0000, 1'b0);
        probe("R5 prog 8FFF", 2'd0, 16'h8FFF, S_RAM, 16'h0FFF, 1'b0);
        probe("R10 prog 9000", 2'd0, 16'h9000, S_EX, 16'h9000, 1'b0);
        probe("R4 gm off data FFFF", 2'd1, 16'hFFFF, S_EX, 16'hFFFF, 1'b0);
    endtask

    task automatic t_low_data;
        probe("R2 data 0000", 2'd1, 16'h0000, S_MMR, 16'h0000, 1'b0);
        probe("R2 data 005F", 2'd1, 16'h005F, S_MMR, 16'h005F, 1'b0);
        probe("R10 data 0060", 2'd1, 16'h0060, S_EX, 16'h0060, 1'b0);
        probe("R7 data 0105", 2'd1, 16'h0105, S_B0, 16'h0005, 1'b0);
        probe("R7 mirror 0205", 2'd1, 16'h0205, S_B0, 16'h0005, 1'b0);
        probe("R7 cfg0 prog FE10", 2'd0, 16'hFE10, S_EX, 16'hFE10, 1'b0);
        probe("R9 data 0342", 2'd1, 16'h0342, S_B1, 16'h0042, 1'b0);
        probe("R9 mirror 0442", 2'd1, 16'h0442, S_B1, 16'h0042, 1'b0);
        probe("R1 io 0100", 2'd2, 16'h0100, S_EX, 16'h0100, 1'b0);
        @(negedge clk); acc_valid = 1'b0;
        #2 compare("R1 idle after access", 6'b0, acc_addr, 1'b0);
    endtask

    task automatic t_global;
        write_gm(4'b1000);
        probe("R3 n0 data FF00", 2'd1, 16'hFF00, S_EX, 16'hFF00, 1'b1);
        probe("R3 n0 data FEFF", 2'd1, 16'hFEFF, S_EX, 16'hFEFF, 1'b0);
        probe("R3 prog FF00", 2'd0, 16'hFF00, S_EX, 16'hFF00, 1'b0);
        probe("R3 io FFFF", 2'd2, 16'hFFFF, S_EX, 16'hFFFF, 1'b0);
        // Enlarge the window in the same cycle as an access to 8000h.
        @(negedge clk);
        gm_we = 1'b1; gm_wdata = 4'b1111;
        acc_valid = 1'b1; acc_space = 2'd1; acc_addr = 16'h8000;
        #2 compare("R11 gm write cycle old", S_EX, 16'h8000, 1'b0);
        @(posedge clk); #1 gm_we = 1'b0;
        #2 compare("R11 R3 n7 data 8000", S_EX, 16'h8000, 1'b1);
        probe("R3 n7 data 7FFF", 2'd1, 16'h7FFF, S_EX, 16'h7FFF, 1'b0);
        write_gm(4'b0111);
        probe("R3 disabled data 8000", 2'd1, 16'h8000, S_EX, 16'h8000, 1'b0);
    endtask

    task automatic t_mode_and_cfg;
        // Clear the mode bit in the same cycle as a program 0000h access.
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 4'b1100;
        acc_valid = 1'b1; acc_space = 2'd0; acc_addr = 16'h0000;
        #2 compare("R11 ctl write cycle old", S_EX, 16'h0000, 1'b0);
        @(posedge clk); #1 ctl_we = 1'b0;
        #2 compare("R11 R6 flash 0000", S_FL, 16'h0000, 1'b0);
        probe("R6 flash 7FFF", 2'd0, 16'h7FFF, S_FL, 16'h7FFF, 1'b0);
        probe("R6 prog 8000 RAM", 2'd0, 16'h8000, S_RAM, 16'h0000, 1'b0);
        write_ctl(4'b1110);
        probe("R8 prog FE00", 2'd0, 16'hFE00, S_B0, 16'h0000, 1'b0);
        probe("R8 mirror FF00", 2'd0, 16'hFF00, S_B0, 16'h0000, 1'b0);
        probe("R8 prog FF7F", 2'd0, 16'hFF7F, S_B0, 16'h007F, 1'b0);
        probe("R8 data 0105 ext", 2'd1, 16'h0105, S_EX, 16'h0105, 1'b0);
        probe("R9 cfg1 data 0342", 2'd1, 16'h0342, S_B1, 16'h0042, 1'b0);
        write_ctl(4'b0010);
        probe("R5 den0 data 0800", 2'd1, 16'h0800, S_EX, 16'h0800, 1'b0);
        probe("R5 pen0 prog 8000", 2'd0, 16'h8000, S_EX, 16'h8000, 1'b0);
        probe("R6 mode0 prog 1234", 2'd0, 16'h1234, S_FL, 16'h1234, 1'b0);
    endtask

    task automatic t_reset_pin_low;
        write_gm(4'b1000);
        do_reset(1'b0);
        mode_pin = 1'b1;
        probe("R4 pin low prog 0000", 2'd0, 16'h0000, S_FL, 16'h0000, 1'b0);
        probe("R4 RAM re-enabled", 2'd1, 16'h0800, S_RAM, 16'h0000, 1'b0);
        probe("R4 gm cleared", 2'd1, 16'hFF00, S_EX, 16'hFF00, 1'b0);
        probe("R4 cfg cleared", 2'd1, 16'h0105, S_B0, 16'h0005, 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset_defaults;
                t_low_data;
                t_global;
                t_mode_and_cfg;
                t_reset_pin_low;
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule